// File: doc/BRIEF.md
# HDLC Status Word Builder

This block assembles the eight-bit status word that an HDLC controller presents to its host. It folds five independent pieces of state into one registered byte. A sticky interrupt flag is fed by a vector of interrupt events, each of which can be masked. An idle-line detector counts consecutive ones on the received serial stream. The frame-position tag of the byte waiting at the head of the receive FIFO is passed through. Two fill-level codes, one for the transmit FIFO and one for the receive FIFO, are derived from occupancy counts compared against a programmable threshold and depth.

The host samples `stat_word` and pulses `stat_rd` in the same cycle to read it. That read returns the byte already on the port. At the next edge the interrupt flag is cleared, unless a new unmasked event arrives in that same cycle. Every field is registered, so each field shows the inputs of the previous clock cycle. The two FIFOs use deliberately different codings for their four states. When several FIFO conditions hold at once, the state is chosen by a fixed priority: empty first, then full, then the threshold comparison.

Top module: `hdlc_stat_word`

## Requirements
- R1: After reset is released with no events and no enabled receive bits, bit 7 and bit 6 of `stat_word` are both 0.
- R2: `stat_word` is registered. Every field reflects the inputs present in the cycle before the rising edge that updates it.
- R3: Bit 7 becomes 1 one cycle after any bit of `irq_evt` is high while the same bit of `irq_mask` is 0. It then holds at 1 until a read clears it.
- R4: An event whose `irq_mask` bit is 1 never sets bit 7.
- R5: A cycle with `stat_rd` high still shows bit 7 as it was. From the following cycle bit 7 reads 0, provided no unmasked event occurred in the read cycle.
- R6: If an unmasked event occurs in the same cycle as `stat_rd`, bit 7 stays 1 after the read.
- R7: Bit 6 becomes 1 one cycle after the 15th consecutive receive bit of value 1 is sampled with `rx_bit_en` high. It stays 1 while further enabled ones arrive, because the run counter saturates.
- R8: An enabled receive bit of 0 drives bit 6 to 0 in the next cycle and restarts the run. Cycles with `rx_bit_en` low leave the run count unchanged.
- R9: Bits 5:4 carry `head_tag` unchanged: 00 packet body byte, 01 first byte, 10 final byte of a good frame, 11 final byte of a bad frame.
- R10: Bits 3:2 encode the transmit FIFO: 00 when the count is at or above depth (full), 01 when the count is at or above the threshold, 10 when the count is zero (empty), 11 when the count is below the threshold.
- R11: Bits 1:0 encode the receive FIFO: 00 when the count is zero (empty), 01 when the count is below the threshold, 10 when the count is at or above depth (full), 11 when the count is at or above the threshold.
- R12: When conditions overlap, empty takes precedence over full, and full takes precedence over the threshold comparison, for both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received serial data bit |
| rx_bit_en | input | 1 | Qualifies `rx_bit` for the idle detector |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_thresh | input | CNT_W | Transmit FIFO threshold level |
| tx_depth | input | CNT_W | Transmit FIFO full level |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_thresh | input | CNT_W | Receive FIFO threshold level |
| rx_depth | input | CNT_W | Receive FIFO full level |
| head_tag | input | 2 | Frame-position tag of the receive FIFO head byte |
| irq_evt | input | IRQ_N | Interrupt event pulses |
| irq_mask | input | IRQ_N | 1 blocks the corresponding event |
| stat_rd | input | 1 | Status read strobe (clears bit 7 after this cycle) |
| stat_word | output | 8 | Registered status byte |

## Verification
The hardest situations to reach are those where two conditions meet in one cycle. One is a read strobe that lands on the same cycle as a fresh unmasked event. The other is a run of ones whose qualifying enables are scattered among disabled cycles. The bench sets up the first case deliberately: it arms the flag, then asserts `stat_rd` and an event together, then follows with a plain read to prove the flag was held and not merely re-set later. For the idle detector it interleaves disabled cycles carrying zeros into a 15-bit run of ones. The flag must then appear exactly after the 15th enabled one and not before.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   localparam int STAT_W = 8;

   typedef enum logic [1:0] {
      TAG_BODY    = 2'b00,
      TAG_FIRST   = 2'b01,
      TAG_END_OK  = 2'b10,
      TAG_END_BAD = 2'b11
   } frame_tag_e;

   typedef enum logic [1:0] {
      TXS_FULL  = 2'b00,
      TXS_ABOVE = 2'b01,
      TXS_EMPTY = 2'b10,
      TXS_BELOW = 2'b11
   } tx_state_e;

   typedef enum logic [1:0] {
      RXS_EMPTY = 2'b00,
      RXS_BELOW = 2'b01,
      RXS_FULL  = 2'b10,
      RXS_ABOVE = 2'b11
   } rx_state_e;

   typedef struct packed {
      logic       irq;
      logic       idle;
      logic [1:0] tag;
      logic [1:0] tx;
      logic [1:0] rx;
   } stat_word_t;

endpackage

// File: rtl/hsw_idle_detect.sv
module hsw_idle_detect #(
   parameter int RUN_LEN = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_in,
   input  logic bit_en,
   output logic idle_nxt
);

   localparam int RUN_W = $clog2(RUN_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);

   generate
      if (RUN_LEN < 2) begin : g_bad_len
         $error("hsw_idle_detect: RUN_LEN must be at least 2");
      end
   endgenerate

   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_d;

   always_comb begin
      run_d = run_q;
      if (bit_en) begin
         if (!bit_in) begin
            run_d = '0;
         end else if (run_q != RUN_TOP) begin
            run_d = run_q + RUN_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
      end else begin
         run_q <= run_d;
      end
   end

   assign idle_nxt = (run_d == RUN_TOP);

   // R7
   run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_TOP);

   // R8
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(run_q));

   // R8
   run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !bit_in) |=> (run_q == '0));

endmodule

// File: rtl/hsw_fifo_level.sv
module hsw_fifo_level
   import hsw_pkg::*;
#(
   parameter int CNT_W = 6,
   parameter bit IS_TX = 1'b1
) (
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thresh,
   input  logic [CNT_W-1:0] depth,
   output logic [1:0]       code
);

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("hsw_fifo_level: CNT_W must be positive");
      end
   endgenerate

   logic is_empty;
   logic is_full;
   logic is_above;

   assign is_empty = (count == '0);
   assign is_full  = (count >= depth);
   assign is_above = (count >= thresh);

   generate
      if (IS_TX) begin : g_tx
         tx_state_e st;
         always_comb begin
            if (is_empty)      st = TXS_EMPTY;
            else if (is_full)  st = TXS_FULL;
            else if (is_above) st = TXS_ABOVE;
            else               st = TXS_BELOW;
         end
         assign code = st;
      end else begin : g_rx
         rx_state_e st;
         always_comb begin
            if (is_empty)      st = RXS_EMPTY;
            else if (is_full)  st = RXS_FULL;
            else if (is_above) st = RXS_ABOVE;
            else               st = RXS_BELOW;
         end
         assign code = st;
      end
   endgenerate

endmodule

// File: rtl/hsw_irq_latch.sv
module hsw_irq_latch #(
   parameter int IRQ_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_N-1:0] evt,
   input  logic [IRQ_N-1:0] mask,
   input  logic             rd,
   output logic             flag_nxt
);

   generate
      if (IRQ_N < 1) begin : g_bad_n
         $error("hsw_irq_latch: IRQ_N must be positive");
      end
   endgenerate

   logic flag_q;
   logic hit;

   assign hit      = |(evt & ~mask);
   assign flag_nxt = hit | (flag_q & ~rd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= flag_nxt;
      end
   end

   // R4
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q && ((evt & ~mask) == '0)) |=> !flag_q);

   // R3
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !rd) |=> flag_q);

endmodule

// File: rtl/hdlc_stat_word.sv
module hdlc_stat_word
   import hsw_pkg::*;
#(
   parameter int CNT_W   = 6,
   parameter int IRQ_N   = 4,
   parameter int RUN_LEN = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_bit,
   input  logic             rx_bit_en,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] tx_thresh,
   input  logic [CNT_W-1:0] tx_depth,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] rx_thresh,
   input  logic [CNT_W-1:0] rx_depth,
   input  logic [1:0]       head_tag,
   input  logic [IRQ_N-1:0] irq_evt,
   input  logic [IRQ_N-1:0] irq_mask,
   input  logic             stat_rd,
   output logic [7:0]       stat_word
);

   generate
      if ($bits(stat_word_t) != STAT_W) begin : g_bad_layout
         $error("hdlc_stat_word: status layout width mismatch");
      end
   endgenerate

   logic       irq_nxt;
   logic       idle_nxt;
   logic [1:0] tx_code;
   logic [1:0] rx_code;
   stat_word_t stat_d;
   stat_word_t stat_q;

   hsw_irq_latch #(.IRQ_N(IRQ_N)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (irq_evt),
      .mask     (irq_mask),
      .rd       (stat_rd),
      .flag_nxt (irq_nxt)
   );

   hsw_idle_detect #(.RUN_LEN(RUN_LEN)) u_idle (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_in   (rx_bit),
      .bit_en   (rx_bit_en),
      .idle_nxt (idle_nxt)
   );

   hsw_fifo_level #(.CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_lvl (
      .count  (tx_count),
      .thresh (tx_thresh),
      .depth  (tx_depth),
      .code   (tx_code)
   );

   hsw_fifo_level #(.CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_lvl (
      .count  (rx_count),
      .thresh (rx_thresh),
      .depth  (rx_depth),
      .code   (rx_code)
   );

   always_comb begin
      stat_d.irq  = irq_nxt;
      stat_d.idle = idle_nxt;
      stat_d.tag  = head_tag;
      stat_d.tx   = tx_code;
      stat_d.rx   = rx_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
      end else begin
         stat_q <= stat_d;
      end
   end

   assign stat_word = stat_q;

   // R3
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_evt & ~irq_mask) != '0) |=> stat_word[7]);

   // R5
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && ((irq_evt & ~irq_mask) == '0)) |=> !stat_word[7]);

   // R8
   idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_bit_en && !rx_bit) |=> !stat_word[6]);

   // R9
   tag_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (stat_word[5:4] == $past(head_tag)));

   // R12
   tx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count == '0) |=> (stat_word[3:2] == 2'b10));

   // R12
   rx_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_count == '0) |=> (stat_word[1:0] == 2'b00));

endmodule

// File: tb/test_hdlc_stat_word.sv
module test_hdlc_stat_word;

   localparam int CNT_W = 6;
   localparam int IRQ_N = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             rx_bit;
   logic             rx_bit_en;
   logic [CNT_W-1:0] tx_count, tx_thresh, tx_depth;
   logic [CNT_W-1:0] rx_count, rx_thresh, rx_depth;
   logic [1:0]       head_tag;
   logic [IRQ_N-1:0] irq_evt, irq_mask;
   logic             stat_rd;
   logic [7:0]       stat_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   hdlc_stat_word #(.CNT_W(CNT_W), .IRQ_N(IRQ_N), .RUN_LEN(15)) i_hdlc_stat_word (
      .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_en(rx_bit_en),
      .tx_count(tx_count), .tx_thresh(tx_thresh), .tx_depth(tx_depth),
      .rx_count(rx_count), .rx_thresh(rx_thresh), .rx_depth(rx_depth),
      .head_tag(head_tag), .irq_evt(irq_evt), .irq_mask(irq_mask),
      .stat_rd(stat_rd), .stat_word(stat_word)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; rx_bit = 1'b0; rx_bit_en = 1'b0;
      tx_count = 6'd5; tx_thresh = 6'd8; tx_depth = 6'd32;
      rx_count = 6'd5; rx_thresh = 6'd8; rx_depth = 6'd32;
      head_tag = 2'b00; irq_evt = '0; irq_mask = '0; stat_rd = 1'b0;
      step(); step();
      rst_n = 1'b1;
      step();
      // R1
      chk("R1 irq after reset", {7'd0, stat_word[7]}, 8'd0);
      chk("R1 idle after reset", {7'd0, stat_word[6]}, 8'd0);
   endtask

   task automatic t_irq();
      irq_mask = 4'b0100; irq_evt = 4'b0100;
      step(); irq_evt = '0; step();
      // R4
      chk("R4 masked event ignored", {7'd0, stat_word[7]}, 8'd0);
      irq_evt = 4'b0010;
      step(); irq_evt = '0;
      // R3
      chk("R3 unmasked event sets", {7'd0, stat_word[7]}, 8'd1);
      step(); step();
      chk("R3 flag sticky", {7'd0, stat_word[7]}, 8'd1);
      stat_rd = 1'b1;
      // R5: read cycle still shows the flag
      chk("R5 read cycle value", {7'd0, stat_word[7]}, 8'd1);
      step(); stat_rd = 1'b0;
      chk("R5 cleared after read", {7'd0, stat_word[7]}, 8'd0);
      irq_evt = 4'b0001; step(); irq_evt = '0;
      stat_rd = 1'b1; irq_evt = 4'b1000;
      step(); stat_rd = 1'b0; irq_evt = '0;
      // R6
      chk("R6 event during read kept", {7'd0, stat_word[7]}, 8'd1);
      stat_rd = 1'b1; step(); stat_rd = 1'b0;
      chk("R6 later read clears", {7'd0, stat_word[7]}, 8'd0);
   endtask

   task automatic t_idle();
      rx_bit_en = 1'b1; rx_bit = 1'b0; step();
      for (int i = 1; i <= 14; i++) begin
         rx_bit = 1'b1; rx_bit_en = 1'b1; step();
         if (i % 4 == 0) begin
            rx_bit_en = 1'b0; rx_bit = 1'b0; step();
         end
      end
      // R8: disabled zeros did not reset the run
      chk("R7 no idle after 14 ones", {7'd0, stat_word[6]}, 8'd0);
      rx_bit_en = 1'b1; rx_bit = 1'b1; step();
      chk("R7 idle after 15 ones", {7'd0, stat_word[6]}, 8'd1);
      for (int i = 0; i < 5; i++) step();
      chk("R7 idle held by saturation", {7'd0, stat_word[6]}, 8'd1);
      rx_bit_en = 1'b0; rx_bit = 1'b0; step(); step();
      chk("R8 disabled zero keeps idle", {7'd0, stat_word[6]}, 8'd1);
      rx_bit_en = 1'b1; step();
      chk("R8 enabled zero clears idle", {7'd0, stat_word[6]}, 8'd0);
      rx_bit = 1'b1; step();
      chk("R8 run restarted", {7'd0, stat_word[6]}, 8'd0);
      rx_bit_en = 1'b0;
   endtask

   task automatic t_tag();
      for (int t = 0; t < 4; t++) begin
         head_tag = 2'(t);
         step();
         // R9
         chk("R9 tag passthrough", {6'd0, stat_word[5:4]}, 8'(t));
      end
      head_tag = 2'b01; @(posedge clk); #1 head_tag = 2'b11;
      // R2: the field shows the value from before the edge
      chk("R2 one-cycle latency", {6'd0, stat_word[5:4]}, 8'd1);
      step();
      chk("R2 updated next edge", {6'd0, stat_word[5:4]}, 8'd3);
   endtask

   task automatic t_fifo();
      tx_thresh = 6'd8; tx_depth = 6'd32; rx_thresh = 6'd8; rx_depth = 6'd32;
      tx_count = 6'd0;  rx_count = 6'd0;  step();
      chk("R10 tx empty", {6'd0, stat_word[3:2]}, 8'd2);
      chk("R11 rx empty", {6'd0, stat_word[1:0]}, 8'd0);
      tx_count = 6'd7;  rx_count = 6'd7;  step();
      chk("R10 tx below", {6'd0, stat_word[3:2]}, 8'd3);
      chk("R11 rx below", {6'd0, stat_word[1:0]}, 8'd1);
      tx_count = 6'd8;  rx_count = 6'd8;  step();
      chk("R10 tx at threshold", {6'd0, stat_word[3:2]}, 8'd1);
      chk("R11 rx at threshold", {6'd0, stat_word[1:0]}, 8'd3);
      tx_count = 6'd32; rx_count = 6'd32; step();
      chk("R10 tx full", {6'd0, stat_word[3:2]}, 8'd0);
      chk("R11 rx full", {6'd0, stat_word[1:0]}, 8'd2);
   endtask

   task automatic t_priority();
      tx_count = 6'd0; tx_depth = 6'd0; tx_thresh = 6'd0;
      rx_count = 6'd0; rx_depth = 6'd0; rx_thresh = 6'd0; step();
      // R12
      chk("R12 tx empty over full", {6'd0, stat_word[3:2]}, 8'd2);
      chk("R12 rx empty over full", {6'd0, stat_word[1:0]}, 8'd0);
      tx_count = 6'd4; tx_depth = 6'd4; tx_thresh = 6'd2;
      rx_count = 6'd4; rx_depth = 6'd4; rx_thresh = 6'd2; step();
      chk("R12 tx full over threshold", {6'd0, stat_word[3:2]}, 8'd0);
      chk("R12 rx full over threshold", {6'd0, stat_word[1:0]}, 8'd2);
   endtask

   initial begin
      t_reset();
      t_irq();
      t_idle();
      t_tag();
      t_fifo();
      t_priority();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule